// File: doc/BRIEF.md
# Compressed Audio Burst Sync Detector

This block sits behind a digital audio receiver. It watches the stream of 16-bit sample words, one per subframe, for the 96-bit preamble that opens a compressed (AC-3/MPEG) burst. The preamble is six words in a row: four zero words, then 0xF872, then 0x4E1F. A separate frame strobe marks frame boundaries.

When the sixth preamble word is accepted, the level output `compressed_flag` goes high. A frame counter then starts. If that counter reaches the window length with no further preamble, the flag goes low again. Every new preamble restarts the counter, so a stream that carries bursts steadily keeps the flag high. Downstream logic uses the flag to tell a compressed payload apart from plain PCM even when the channel-status bits are set wrongly.

The word input is a valid/ready stream. `word_ready` is always high, so the block never applies back-pressure. A word is consumed on every clock edge where `word_valid` is high. While `word_valid` is low the word lines are ignored, and a gap does not break a preamble that is partly matched.

Top module: `burst_sync_detect`

## Requirements
- R1: While `rst_n` is low, `compressed_flag` is low and the matcher is idle. A preamble that is partly received before reset cannot complete after reset.
- R2: `word_ready` is always 1. Cycles with `word_valid` low neither advance nor break a partial preamble.
- R3: `compressed_flag` becomes 1 on the clock edge that accepts the sixth preamble word (0x4E1F). It never rises without a completed preamble.
- R4: A word that does not match the next expected preamble word abandons the partial match. Sequences with only three leading zeros, with a wrong fifth word, or with an extra word inserted do not raise the flag.
- R5: A run of more than four zero words followed by 0xF872 and 0x4E1F is detected.
- R6: With no new preamble, `compressed_flag` falls on the edge that counts the WINDOW-th (default 4096) `frame_tick` after the last detection.
- R7: A preamble detected while the flag is high restarts the frame count from zero. If a detection and a frame tick arrive on the same edge, the detection wins.
- R8: After the flag has fallen, the next complete preamble raises it again.
- R9: Only `frame_tick` advances the hold-off count. Accepted words, however many, do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_valid | input | 1 | Word on `word_data` is offered |
| word_ready | output | 1 | Always 1, no back-pressure |
| word_data | input | 16 | Received audio word |
| frame_tick | input | 1 | One-cycle strobe per audio frame |
| compressed_flag | output | 1 | High while compressed bursts are being seen |

## Verification
A matcher state that slips shows up at the flag on the edge that accepts the sixth word. The flag either fails to rise there, or it rises after a near-miss sequence. A bad hold-off count stays hidden until the window boundary. There it drops the flag one or more ticks early or late, or fails to drop it at all. Because of this, the bench compares the flag with its model on every cycle and steps the flag across the exact tick of each expected fall.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int WORD_W   = 16;
  localparam int SYNC_LEN = 6;
  localparam int ZERO_RUN = 4;

  // Preamble words in arrival order
  localparam logic [WORD_W-1:0] SYNC_WORDS [SYNC_LEN] = '{
    16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hF872, 16'h4E1F
  };
endpackage

// File: rtl/bsd_matcher.sv
module bsd_matcher
  import bsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              hit
);
  localparam int ST_W = $clog2(SYNC_LEN);

  logic [ST_W-1:0]     state, state_nxt;
  logic [SYNC_LEN-1:0] eq;
  logic                zero_w;

  // One comparator per preamble position
  for (genvar i = 0; i < SYNC_LEN; i++) begin : g_cmp
    assign eq[i] = (word_data == SYNC_WORDS[i]);
  end

  assign zero_w = (word_data == '0);

  always_comb begin
    state_nxt = state;
    hit       = 1'b0;
    if (word_valid) begin
      if (eq[state]) begin
        if (int'(state) == SYNC_LEN-1) begin
          hit       = 1'b1;
          state_nxt = '0;
        end else begin
          state_nxt = state + 1'b1;
        end
      end else if (zero_w) begin
        // A zero past the leading run: either the run continues, or a new run starts
        state_nxt = (int'(state) == ZERO_RUN) ? ST_W'(ZERO_RUN) : ST_W'(1);
      end else begin
        state_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_nxt;
  end

  AST_GAP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(state)); // R2
  AST_HIT_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (word_valid && word_data == SYNC_WORDS[SYNC_LEN-1])); // R3
  AST_BAD_WORD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_data != '0 && !eq[state]) |=> (state == '0)); // R4
endmodule

// File: rtl/bsd_holdoff.sv
module bsd_holdoff #(
  parameter int WINDOW = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic frame_tick,
  output logic flag
);
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW-1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (hit) begin
      flag <= 1'b1;
      cnt  <= '0;
    end else if (flag && frame_tick) begin
      if (cnt == LAST) begin
        flag <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_RISE_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R3
  AST_RISE_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit)); // R3
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(frame_tick)); // R9
  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !frame_tick && !hit) |=> $stable(cnt)); // R9
  AST_HIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0)); // R7
endmodule

// File: rtl/burst_sync_detect.sv
module burst_sync_detect
  import bsd_pkg::*;
#(
  parameter int WINDOW = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic              frame_tick,
  output logic              compressed_flag
);
  logic hit;

  assign word_ready = 1'b1;

  bsd_matcher u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .word_data  (word_data),
    .hit        (hit)
  );

  bsd_holdoff #(.WINDOW(WINDOW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (hit),
    .frame_tick (frame_tick),
    .flag       (compressed_flag)
  );

  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !compressed_flag); // R1
endmodule

// File: tb/burst_sync_detect_bench.sv
module burst_sync_detect_bench;
  localparam int WINDOW = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [15:0] word_data = '0;
  logic        frame_tick = 1'b0;
  logic        compressed_flag;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  burst_sync_detect #(.WINDOW(WINDOW)) u_burst_sync_detect (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .frame_tick(frame_tick), .compressed_flag(compressed_flag)
  );

  // Behavioural reference: sliding window of the last six accepted words
  logic [15:0] pat [6] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hF872, 16'h4E1F};
  logic [15:0] hist [$];
  bit exp_flag = 1'b0;
  int exp_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      exp_flag = 1'b0;
      exp_cnt = 0;
    end else begin
      bit h;
      h = 1'b0;
      if (word_valid) begin
        hist.push_back(word_data);
        if (hist.size() > 6) void'(hist.pop_front());
        if (hist.size() == 6) begin
          h = 1'b1;
          for (int k = 0; k < 6; k++) if (hist[k] != pat[k]) h = 1'b0;
        end
      end
      if (h) begin
        exp_flag = 1'b1;
        exp_cnt = 0;
      end else if (exp_flag && frame_tick) begin
        exp_cnt++;
        if (exp_cnt == WINDOW) begin
          exp_flag = 1'b0;
          exp_cnt = 0;
        end
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      checks++;
      if (compressed_flag !== exp_flag) begin
        errors++;
        $display("FAIL %s cycle %0d: flag actual=%0b expected=%0b", cur_req, cycles, compressed_flag, exp_flag);
      end
      checks++;
      if (word_ready !== 1'b1) begin
        errors++;
        $display("FAIL R2 cycle %0d: ready actual=%0b expected=1", cycles, word_ready);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic step(input bit v, input logic [15:0] w, input bit t);
    @(negedge clk);
    #1;
    word_valid = v;
    word_data  = w;
    frame_tick = t;
  endtask

  task automatic idle();
    step(1'b0, 16'hDEAD, 1'b0);
  endtask

  task automatic expect_flag(input bit e, input string req);
    checks++;
    if (compressed_flag !== e) begin
      errors++;
      $display("FAIL %s: flag actual=%0b expected=%0b", req, compressed_flag, e);
    end
  endtask

  task automatic send_pattern(input bit gaps);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, pat[k], 1'b0);
      if (gaps) idle();
    end
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b1, 16'h1111, 1'b1);
      step(1'b0, 16'h0000, 1'b0);
    end
  endtask

  initial begin
    // R1: reset state and a partial preamble cut by reset
    repeat (3) @(negedge clk);
    expect_flag(1'b0, "R1");
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) step(1'b1, pat[k], 1'b0);
    step(1'b0, 16'h0, 1'b0);
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    step(1'b1, 16'h4E1F, 1'b0);
    idle();
    expect_flag(1'b0, "R1");

    // R4: near misses
    cur_req = "R4";
    step(1'b1, 16'h0, 1'b0); step(1'b1, 16'h0, 1'b0); step(1'b1, 16'h0, 1'b0);
    step(1'b1, 16'hF872, 1'b0); step(1'b1, 16'h4E1F, 1'b0); idle();
    expect_flag(1'b0, "R4");
    for (int k = 0; k < 5; k++) step(1'b1, pat[k], 1'b0);
    step(1'b1, 16'h1234, 1'b0); step(1'b1, 16'h4E1F, 1'b0); idle();
    expect_flag(1'b0, "R4");
    for (int k = 0; k < 4; k++) step(1'b1, 16'h0, 1'b0);
    step(1'b1, 16'hF873, 1'b0); step(1'b1, 16'h4E1F, 1'b0); idle();
    expect_flag(1'b0, "R4");

    // R5: long zero run, R3: rise right after the last word
    cur_req = "R5";
    for (int k = 0; k < 7; k++) step(1'b1, 16'h0, 1'b0);
    step(1'b1, 16'hF872, 1'b0);
    step(1'b1, 16'h4E1F, 1'b0);
    idle();
    expect_flag(1'b1, "R3");
    expect_flag(1'b1, "R5");

    // R9: many words without ticks keep the flag
    cur_req = "R9";
    for (int k = 0; k < 5000; k++) step(1'b1, 16'h2222, 1'b0);
    idle();
    expect_flag(1'b1, "R9");

    // R6: fall on exactly the WINDOW-th tick
    cur_req = "R6";
    ticks(WINDOW - 1);
    expect_flag(1'b1, "R6");
    step(1'b0, 16'h0, 1'b1);
    idle();
    expect_flag(1'b0, "R6");

    // R2 + R8: preamble with gaps raises flag again
    cur_req = "R8";
    send_pattern(1'b1);
    idle();
    expect_flag(1'b1, "R8");
    expect_flag(1'b1, "R2");

    // R7: retrigger midway; detection and tick on the same edge
    cur_req = "R7";
    ticks(2000);
    for (int k = 0; k < 5; k++) step(1'b1, pat[k], 1'b0);
    step(1'b1, 16'h4E1F, 1'b1);
    idle();
    ticks(WINDOW - 1);
    expect_flag(1'b1, "R7");
    ticks(1);
    expect_flag(1'b0, "R7");

    repeat (3) idle();
    finish_run();
  end
endmodule